// File: doc/BRIEF.md
# Two-Source Interrupt Controller

This block is the interrupt unit beside a small 4-bit processor core. It watches two sources: a one-cycle overflow pulse from an 8-bit timer (issued when the counter wraps from 0xFF back to 0x00) and a falling-edge detector on a group of input pins. Each source owns a request flag and an enable flag. The flags sit in two 4-bit system registers that the core reads and writes over a plain register bus.

The core marks the end of every instruction with a one-cycle strobe. When a source has both its request and its enable set, the controller arms. It lets the current instruction and then two further instructions finish before it dispatches. If a request or enable is cleared during that window, the dispatch is cancelled. On dispatch it emits a one-cycle take pulse, which tells the core to push its program counter and carry flag. It also presents the vector address of the winning source and clears every enable flag. While the timer request and the timer enable are both set, a wake line tells a halted core to resume.

Top module: `dual_src_irq_ctrl`

## Requirements
- R1: After reset both registers read 0, and `irq_take`, `irq_vector` and `wake` are 0.
- R2: A cycle with `tmr_ovf` high sets the timer request (bit 3 of the request register, `reg_sel`=0). The flag reads 1 from the next cycle on.
- R3: When a pin whose bit is set in `port_edge_mask` is sampled 1 and then 0 on the next clock, the port request (bit 0 of the request register) is set, readable one cycle after the pin falls. A fall on a masked pin, or any rise, does not set it.
- R4: Bits 2 and 1 of both registers always read 0, and writing 1 to them has no effect.
- R5: A write to the request register loads bits 3 and 0 from `reg_wdata`, so writing 0 clears a flag. A hardware set in the same cycle wins over that clear.
- R6: A take happens only if, on the edge before the take pulse, some source had both its request and its enable (`reg_sel`=1, same bit positions) at 1.
- R7: Call the first cycle in which a source is qualified the arming cycle. A strobe in that cycle ends instruction N. The take pulse appears in the cycle after the clock edge that samples the third strobe counted from the arming cycle. Cycles without a strobe do not advance the count.
- R8: If no source stays qualified (a request or enable was cleared) before that third strobe, the dispatch is cancelled. A later qualification starts a new count from zero.
- R9: `irq_take` is high for exactly one cycle. On the same edge every enable flag clears to 0, while request flags keep their values.
- R10: With both sources qualified, the timer wins and `irq_vector` shows the timer vector (0x008). The port request stays pending and, once the timer is no longer qualified and the port is enabled again, dispatches with the port vector (0x00C).
- R11: `wake` is 1 exactly while the timer request and the timer enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_sel | input | 1 | Register select: 0 request flags, 1 enable flags |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Read data of the selected register (combinational) |
| tmr_ovf | input | 1 | Timer wrap pulse |
| port_pins | input | 4 | Port input pins watched for falling edges |
| port_edge_mask | input | 4 | Per-pin enable of the edge detector |
| insn_done | input | 1 | Instruction-boundary strobe from the core |
| irq_take | output | 1 | Accept pulse: core stacks PC and carry and jumps |
| irq_vector | output | 12 | Vector address of the accepted source |
| wake | output | 1 | Wake request for a halted core |

## Verification
Flag results are due one clock after their stimulus: a timer pulse, a pin fall or a register write becomes readable in the next cycle. The take pulse is due in the cycle after the edge that samples the third boundary strobe, and the enable clear lands on that same edge. The bench drives every input just after a falling edge and samples on the following falling edge, so each result is read exactly one edge after it was caused. A monitor pops a queued vector for every take pulse, which also catches early, late, extra or doubled pulses.

// File: rtl/dsic_pkg.sv
package dsic_pkg;

   typedef enum logic {
      DSP_IDLE = 1'b0,
      DSP_WAIT = 1'b1
   } dsp_state_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/dsic_edge_detect.sv
module dsic_edge_detect #(
   parameter int unsigned PORT_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PORT_W-1:0] pins,
   input  logic [PORT_W-1:0] mask,
   output logic              fall
);

   logic [PORT_W-1:0] prev_q;
   logic [PORT_W-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= pins;
   end

   for (genvar i = 0; i < PORT_W; i++) begin : g_pin
      assign hit[i] = mask[i] & prev_q[i] & ~pins[i];
   end

   assign fall = |hit;

endmodule

// File: rtl/dsic_flag_regs.sv
module dsic_flag_regs #(
   parameter int unsigned REG_W    = 4,
   parameter int unsigned TMR_BIT  = 3,
   parameter int unsigned PORT_BIT = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_sel,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic             set_tmr,
   input  logic             set_port,
   input  logic             drop_en,
   output logic [REG_W-1:0] rdata,
   output logic             tmr_req,
   output logic             port_req,
   output logic             tmr_en,
   output logic             port_en
);

   localparam logic [REG_W-1:0] ONE  = {{(REG_W-1){1'b0}}, 1'b1};
   localparam logic [REG_W-1:0] USED = (ONE << TMR_BIT) | (ONE << PORT_BIT);

   logic [REG_W-1:0] req_q;
   logic [REG_W-1:0] en_q;
   logic [REG_W-1:0] hw_set;
   logic             wr_req;
   logic             wr_en;

   assign wr_req = reg_wr & ~reg_sel;
   assign wr_en  = reg_wr &  reg_sel;

   always_comb begin
      hw_set           = '0;
      hw_set[TMR_BIT]  = set_tmr;
      hw_set[PORT_BIT] = set_port;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= '0;
      end else if (wr_req) begin
         req_q <= (reg_wdata & USED) | hw_set;
      end else begin
         req_q <= req_q | hw_set;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
      end else if (drop_en) begin
         en_q <= '0;
      end else if (wr_en) begin
         en_q <= reg_wdata & USED;
      end
   end

   assign rdata    = reg_sel ? en_q : req_q;
   assign tmr_req  = req_q[TMR_BIT];
   assign port_req = req_q[PORT_BIT];
   assign tmr_en   = en_q[TMR_BIT];
   assign port_en  = en_q[PORT_BIT];

endmodule

// File: rtl/dsic_prio.sv
module dsic_prio #(
   parameter int unsigned     VEC_W       = 12,
   parameter logic [VEC_W-1:0] TMR_VEC    = 12'h008,
   parameter logic [VEC_W-1:0] PORT_VEC   = 12'h00C,
   parameter bit               TIMER_FIRST = 1'b1
) (
   input  logic             tmr_req,
   input  logic             tmr_en,
   input  logic             port_req,
   input  logic             port_en,
   output logic             qual_any,
   output logic [VEC_W-1:0] vec
);

   logic tmr_q;
   logic port_q;

   assign tmr_q    = tmr_req  & tmr_en;
   assign port_q   = port_req & port_en;
   assign qual_any = tmr_q | port_q;

   if (TIMER_FIRST) begin : g_tmr_first
      assign vec = tmr_q ? TMR_VEC : PORT_VEC;
   end else begin : g_port_first
      assign vec = port_q ? PORT_VEC : TMR_VEC;
   end

endmodule

// File: rtl/dsic_dispatch.sv
module dsic_dispatch
   import dsic_pkg::*;
#(
   parameter int unsigned FOLLOW_INSNS = 2,
   parameter int unsigned VEC_W        = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             qual_any,
   input  logic             insn_done,
   input  logic [VEC_W-1:0] vec_sel,
   output logic             fire,
   output logic             take_q,
   output logic [VEC_W-1:0] vec_q
);

   localparam int unsigned      CNT_W = cnt_width(FOLLOW_INSNS + 1);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(FOLLOW_INSNS);
   localparam logic [CNT_W-1:0] STEP  = CNT_W'(1);

   dsp_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;

   assign fire = (state_q == DSP_WAIT) && qual_any && insn_done && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= DSP_IDLE;
         cnt_q   <= '0;
         take_q  <= 1'b0;
         vec_q   <= '0;
      end else begin
         take_q <= fire;
         if (fire) vec_q <= vec_sel;
         case (state_q)
            DSP_IDLE: begin
               if (qual_any) begin
                  state_q <= DSP_WAIT;
                  cnt_q   <= insn_done ? STEP : '0;
               end
            end
            DSP_WAIT: begin
               if (!qual_any || fire) begin
                  state_q <= DSP_IDLE;
                  cnt_q   <= '0;
               end else if (insn_done) begin
                  cnt_q <= cnt_q + STEP;
               end
            end
            default: begin
               state_q <= DSP_IDLE;
               cnt_q   <= '0;
            end
         endcase
      end
   end

endmodule

// File: rtl/dual_src_irq_ctrl.sv
module dual_src_irq_ctrl #(
   parameter int unsigned      REG_W        = 4,
   parameter int unsigned      PORT_W       = 4,
   parameter int unsigned      TMR_BIT      = 3,
   parameter int unsigned      PORT_BIT     = 0,
   parameter int unsigned      VEC_W        = 12,
   parameter logic [VEC_W-1:0] TMR_VEC      = 12'h008,
   parameter logic [VEC_W-1:0] PORT_VEC     = 12'h00C,
   parameter int unsigned      FOLLOW_INSNS = 2,
   parameter bit               TIMER_FIRST  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_sel,
   input  logic              reg_wr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              tmr_ovf,
   input  logic [PORT_W-1:0] port_pins,
   input  logic [PORT_W-1:0] port_edge_mask,
   input  logic              insn_done,
   output logic              irq_take,
   output logic [VEC_W-1:0]  irq_vector,
   output logic              wake
);

   if (TMR_BIT >= REG_W || PORT_BIT >= REG_W) begin : g_bad_bit_pos
      $error("flag bit position outside the register width");
   end
   if (TMR_BIT == PORT_BIT) begin : g_bad_bit_share
      $error("timer and port flags must use distinct bits");
   end
   if (FOLLOW_INSNS < 1) begin : g_bad_follow
      $error("at least one following instruction is required");
   end
   if (PORT_W < 1) begin : g_bad_port_w
      $error("port width must be at least one");
   end

   logic             port_fall;
   logic             tmr_req;
   logic             port_req;
   logic             tmr_en;
   logic             port_en;
   logic             qual_any;
   logic             fire;
   logic [VEC_W-1:0] vec_sel;

   dsic_edge_detect #(.PORT_W(PORT_W)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .pins  (port_pins),
      .mask  (port_edge_mask),
      .fall  (port_fall)
   );

   dsic_flag_regs #(
      .REG_W    (REG_W),
      .TMR_BIT  (TMR_BIT),
      .PORT_BIT (PORT_BIT)
   ) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_sel   (reg_sel),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .set_tmr   (tmr_ovf),
      .set_port  (port_fall),
      .drop_en   (fire),
      .rdata     (reg_rdata),
      .tmr_req   (tmr_req),
      .port_req  (port_req),
      .tmr_en    (tmr_en),
      .port_en   (port_en)
   );

   dsic_prio #(
      .VEC_W       (VEC_W),
      .TMR_VEC     (TMR_VEC),
      .PORT_VEC    (PORT_VEC),
      .TIMER_FIRST (TIMER_FIRST)
   ) u_prio (
      .tmr_req  (tmr_req),
      .tmr_en   (tmr_en),
      .port_req (port_req),
      .port_en  (port_en),
      .qual_any (qual_any),
      .vec      (vec_sel)
   );

   dsic_dispatch #(
      .FOLLOW_INSNS (FOLLOW_INSNS),
      .VEC_W        (VEC_W)
   ) u_dispatch (
      .clk       (clk),
      .rst_n     (rst_n),
      .qual_any  (qual_any),
      .insn_done (insn_done),
      .vec_sel   (vec_sel),
      .fire      (fire),
      .take_q    (irq_take),
      .vec_q     (irq_vector)
   );

   assign wake = tmr_req & tmr_en;

endmodule

// File: rtl/dual_src_irq_ctrl_chk.sv
module dual_src_irq_ctrl_chk #(
   parameter int unsigned      REG_W       = 4,
   parameter int unsigned      TMR_BIT     = 3,
   parameter int unsigned      PORT_BIT    = 0,
   parameter int unsigned      VEC_W       = 12,
   parameter logic [VEC_W-1:0] TMR_VEC     = 12'h008,
   parameter logic [VEC_W-1:0] PORT_VEC    = 12'h00C,
   parameter bit               TIMER_FIRST = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tmr_ovf,
   input logic [REG_W-1:0] reg_rdata,
   input logic             irq_take,
   input logic [VEC_W-1:0] irq_vector,
   input logic             tmr_req,
   input logic             port_req,
   input logic             tmr_en,
   input logic             port_en
);

   localparam logic [REG_W-1:0] ONE    = {{(REG_W-1){1'b0}}, 1'b1};
   localparam logic [REG_W-1:0] UNUSED = ~((ONE << TMR_BIT) | (ONE << PORT_BIT));
   localparam logic [VEC_W-1:0] WINNER = TIMER_FIRST ? TMR_VEC : PORT_VEC;

   // R2
   a_r2_timer_sets_request: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf |=> tmr_req);

   // R4
   a_r4_unused_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rdata & UNUSED) == '0);

   // R6
   a_r6_take_needs_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> $past((tmr_req && tmr_en) || (port_req && port_en)));

   // R9
   a_r9_enables_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> (!tmr_en && !port_en));

   // R9
   a_r9_take_single: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> !irq_take);

   // R10
   a_r10_priority: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_take && $past(tmr_req && tmr_en && port_req && port_en)) |-> irq_vector == WINNER);

endmodule

bind dual_src_irq_ctrl dual_src_irq_ctrl_chk #(
   .REG_W       (REG_W),
   .TMR_BIT     (TMR_BIT),
   .PORT_BIT    (PORT_BIT),
   .VEC_W       (VEC_W),
   .TMR_VEC     (TMR_VEC),
   .PORT_VEC    (PORT_VEC),
   .TIMER_FIRST (TIMER_FIRST)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tmr_ovf    (tmr_ovf),
   .reg_rdata  (reg_rdata),
   .irq_take   (irq_take),
   .irq_vector (irq_vector),
   .tmr_req    (tmr_req),
   .port_req   (port_req),
   .tmr_en     (tmr_en),
   .port_en    (port_en)
);

// File: tb/dual_src_irq_ctrl_test.sv
`timescale 1ns/1ps
module dual_src_irq_ctrl_test;

   localparam logic [11:0] V_TMR  = 12'h008;
   localparam logic [11:0] V_PORT = 12'h00C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_sel = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_wdata = '0;
   logic [3:0]  reg_rdata;
   logic        tmr_ovf = 1'b0;
   logic [3:0]  port_pins = 4'hF;
   logic [3:0]  port_edge_mask = '0;
   logic        insn_done = 1'b0;
   logic        irq_take;
   logic [11:0] irq_vector;
   logic        wake;

   int n_chk = 0;
   int n_err = 0;
   logic [11:0] exp_q[$];

   always #5 clk = ~clk;

   dual_src_irq_ctrl uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .reg_sel        (reg_sel),
      .reg_wr         (reg_wr),
      .reg_wdata      (reg_wdata),
      .reg_rdata      (reg_rdata),
      .tmr_ovf        (tmr_ovf),
      .port_pins      (port_pins),
      .port_edge_mask (port_edge_mask),
      .insn_done      (insn_done),
      .irq_take       (irq_take),
      .irq_vector     (irq_vector),
      .wake           (wake)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   // monitor: every take pulse must match the next queued vector
   always @(negedge clk) begin
      if (rst_n && irq_take) begin
         if (exp_q.size() == 0) begin
            chk("R6 unexpected take", {20'd0, irq_vector}, 32'hFFFF_FFFF);
         end else begin
            chk("R10 vector", {20'd0, irq_vector}, {20'd0, exp_q.pop_front()});
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk("watchdog", 32'd1, 32'd0);
      summary();
   end

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic wr(input logic sel, input logic [3:0] d);
      reg_sel = sel; reg_wr = 1'b1; reg_wdata = d;
      cyc();
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input string req, input logic sel, input logic [3:0] exp);
      reg_sel = sel;
      #1;
      chk(req, {28'd0, reg_rdata}, {28'd0, exp});
   endtask

   task automatic pulse_tmr();
      tmr_ovf = 1'b1;
      cyc();
      tmr_ovf = 1'b0;
   endtask

   task automatic strobes(input int n);
      for (int i = 0; i < n; i++) begin
         insn_done = 1'b1;
         cyc();
      end
      insn_done = 1'b0;
   endtask

   initial begin
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();

      // R1 reset state
      rd("R1 request reg", 1'b0, 4'h0);
      rd("R1 enable reg", 1'b1, 4'h0);
      chk("R1 take", {31'd0, irq_take}, 32'd0);
      chk("R1 vector", {20'd0, irq_vector}, 32'd0);
      chk("R1 wake", {31'd0, wake}, 32'd0);

      // R2 timer request, R11 wake
      pulse_tmr();
      rd("R2 timer request", 1'b0, 4'h8);
      chk("R11 wake without enable", {31'd0, wake}, 32'd0);
      wr(1'b1, 4'h8);
      chk("R11 wake with enable", {31'd0, wake}, 32'd1);

      // R8 request cleared while armed: no take
      wr(1'b0, 4'h0);
      chk("R11 wake after clear", {31'd0, wake}, 32'd0);
      strobes(3);
      cyc();
      rd("R8 request cleared", 1'b0, 4'h0);
      rd("R8 enable kept", 1'b1, 4'h8);
      wr(1'b1, 4'h0);

      // R4 unused bits
      wr(1'b0, 4'hF);
      rd("R4 request unused", 1'b0, 4'h9);
      wr(1'b0, 4'h0);
      wr(1'b1, 4'h6);
      rd("R4 enable unused", 1'b1, 4'h0);

      // R3 port edges
      port_edge_mask = 4'b0010;
      cyc();
      port_pins = 4'b1110;
      cyc(); cyc();
      rd("R3 masked pin fall", 1'b0, 4'h0);
      port_pins = 4'b1111;
      cyc();
      rd("R3 rising edge", 1'b0, 4'h0);
      port_pins = 4'b1101;
      cyc();
      rd("R3 enabled pin fall", 1'b0, 4'h1);
      port_pins = 4'b1111;
      wr(1'b0, 4'h0);
      rd("R5 software clear", 1'b0, 4'h0);

      // R5 hardware set wins over clear
      tmr_ovf = 1'b1; reg_sel = 1'b0; reg_wr = 1'b1; reg_wdata = 4'h0;
      cyc();
      tmr_ovf = 1'b0; reg_wr = 1'b0;
      rd("R5 set beats clear", 1'b0, 4'h8);

      // R7 dispatch on third boundary, R9 enable drop
      wr(1'b1, 4'h8);
      strobes(1);
      repeat (4) cyc();
      chk("R7 no take after one boundary", {31'd0, irq_take}, 32'd0);
      strobes(1);
      chk("R7 no take after two boundaries", {31'd0, irq_take}, 32'd0);
      repeat (3) cyc();
      exp_q.push_back(V_TMR);
      strobes(1);
      chk("R7 take after third boundary", {31'd0, irq_take}, 32'd1);
      rd("R9 enables cleared", 1'b1, 4'h0);
      rd("R9 request kept", 1'b0, 4'h8);
      cyc();
      chk("R9 take is one cycle", {31'd0, irq_take}, 32'd0);

      // R8 enable cleared mid-window, then fresh count
      wr(1'b1, 4'h8);
      strobes(1);
      wr(1'b1, 4'h0);
      strobes(3);
      cyc();
      chk("R8 no take after enable drop", {31'd0, irq_take}, 32'd0);
      wr(1'b1, 4'h8);
      strobes(2);
      chk("R8 count restarts", {31'd0, irq_take}, 32'd0);
      exp_q.push_back(V_TMR);
      strobes(1);
      chk("R8 take after fresh count", {31'd0, irq_take}, 32'd1);
      wr(1'b0, 4'h0);

      // R10 priority and pending loser
      tmr_ovf = 1'b1; port_pins = 4'b1101;
      cyc();
      tmr_ovf = 1'b0;
      rd("R10 both requests", 1'b0, 4'h9);
      wr(1'b1, 4'h9);
      exp_q.push_back(V_TMR);
      strobes(3);
      cyc();
      rd("R10 loser pending", 1'b0, 4'h9);
      rd("R10 enables cleared", 1'b1, 4'h0);
      wr(1'b0, 4'h1);
      wr(1'b1, 4'h1);
      exp_q.push_back(V_PORT);
      strobes(3);
      cyc();
      rd("R9 enables cleared after port", 1'b1, 4'h0);
      port_pins = 4'hF;

      repeat (5) cyc();
      chk("R7 all expected takes seen", exp_q.size(), 32'd0);
      summary();
   end

endmodule